// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor in which program and data live in the same memory and travel over one synchronous memory port. All arithmetic goes through a single 16-bit accumulator. Every instruction runs as a fixed series of register transfers. The program counter is copied into an address register, and the memory word is taken into a data register and then into the instruction register. The instruction is decoded, any operand reads follow, and the execute step comes last. Each memory access has its own state, and the memory returns read data one cycle after the read strobe.

The instruction word is 16 bits: opcode in bits [15:12], addressing mode in bits [11:10] and a 10-bit operand in bits [9:0]. The operand is resolved in one of four ways: as a literal, as an address, as a pointer to an address, or as an address offset by the index register. For jumps, mode 0 gives a PC-relative target. A compare instruction sets an equality flag, and two conditional jumps test that flag. The core is meant to sit next to a 1024-word single-port RAM with one cycle of read latency. It starts running from address 0 when the synchronous reset is released.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core clears PC, ACC, the index register and all flags, and drives `mem_rd` and `mem_wr` low. The first instruction is fetched from address 0.
- R2: Fetch takes four states: PC to the address register; a read with `mem_rd` high at that address, during which PC increments by one; capture of `mem_rdata` one cycle later; and a copy into the instruction register. Decode is the fifth state. An immediate load therefore issues its next fetch read 6 cycles after its own.
- R3: Opcodes in bits [15:12]: 0 load, 1 store, 2 add, 3 subtract, 4 increment, 5 decrement, 6 compare, 7 jump, 8 jump-if-equal, 9 jump-if-not-equal, 10 load index. Any other opcode is a no-op. Modes in bits [11:10]: 0 immediate, 1 direct, 2 indirect, 3 indexed.
- R4: In immediate mode the operand value is the 10-bit field zero-extended, and no memory read is made for it.
- R5: In direct mode the operand field is the data address. In indirect mode the word at that address is read first, and its low 10 bits are the data address.
- R6: In indexed mode the data address is the operand field plus the index register, modulo 1024. Opcode 10 loads the index register with the low 10 bits of the operand value.
- R7: A store writes ACC to the resolved address with `mem_wr` high for one cycle. A store in immediate mode writes nothing.
- R8: Add, subtract, increment and decrement wrap modulo 2^16 and update the zero flag and the signed-overflow flag. A load changes neither flag.
- R9: Compare sets the equality flag to (ACC == operand value) and leaves ACC, zero and overflow unchanged.
- R10: Jump is always taken. Jump-if-equal is taken only when the equality flag is 1, and jump-if-not-equal only when it is 0. The target is: mode 0, the incremented PC plus the sign-extended operand; mode 1, the operand; mode 2, the word at the operand address; mode 3, the operand plus the index register.
- R11: `status` shows overflow in bit 2, zero in bit 1 and equality in bit 0. It changes only in the execute state.
- R12: `mem_rd` and `mem_wr` are never high together. PC changes only in the fetch-read state and in the execute state of a taken jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 10 | Memory word address (the address register) |
| mem_rd | output | 1 | Read strobe; data is valid on `mem_rdata` the next cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data from memory |
| status | output | 3 | {overflow, zero, equal} flags |

## Verification
The bench probes the boundaries of signed overflow: 0x7FFF incremented, 0x8000 decremented, and wrap through zero. A design that computed overflow from the unsigned carry would flag 0xFFFF+1 and miss 0x7FFF+1. A directed program covers a two-level pointer load and a pointer store. Taking the low bits of the pointer word, rather than reading through it, would put the data at the wrong address. The same program covers an immediate-mode store, which must leave memory untouched. It also checks every jump variant with its flag both set and clear. A relative jump computed from the PC before the increment would land one word early and execute a store that is meant to be skipped. Index wrap-around and fetch timing are checked against the cycle of each read strobe.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W  = 4;
  localparam int MODE_W = 2;

  localparam logic [OPC_W-1:0] OP_LDA = 4'h0;
  localparam logic [OPC_W-1:0] OP_STA = 4'h1;
  localparam logic [OPC_W-1:0] OP_ADD = 4'h2;
  localparam logic [OPC_W-1:0] OP_SUB = 4'h3;
  localparam logic [OPC_W-1:0] OP_INC = 4'h4;
  localparam logic [OPC_W-1:0] OP_DEC = 4'h5;
  localparam logic [OPC_W-1:0] OP_CMP = 4'h6;
  localparam logic [OPC_W-1:0] OP_JMP = 4'h7;
  localparam logic [OPC_W-1:0] OP_JPE = 4'h8;
  localparam logic [OPC_W-1:0] OP_JPN = 4'h9;
  localparam logic [OPC_W-1:0] OP_LIX = 4'hA;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM = 2'd0,
    AM_DIR = 2'd1,
    AM_IND = 2'd2,
    AM_IDX = 2'd3
  } amode_e;

  typedef enum logic [3:0] {
    ST_FADDR,
    ST_FREAD,
    ST_FCAP,
    ST_CIR,
    ST_DECODE,
    ST_PREAD,
    ST_PCAP,
    ST_PMAR,
    ST_OREAD,
    ST_OCAP,
    ST_STORE,
    ST_EXEC
  } state_e;

  function automatic logic op_is_jump(input logic [OPC_W-1:0] op);
    return (op == OP_JMP) || (op == OP_JPE) || (op == OP_JPN);
  endfunction

  function automatic logic op_uses_data(input logic [OPC_W-1:0] op);
    return (op == OP_LDA) || (op == OP_ADD) || (op == OP_SUB) ||
           (op == OP_CMP) || (op == OP_LIX);
  endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              res_zero,
  output logic              res_ovf,
  output logic              acc_we,
  output logic              flag_we,
  output logic              is_equal
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  function automatic logic add_ovf(input logic [DATA_W-1:0] x, y, s);
    return (x[DATA_W-1] == y[DATA_W-1]) && (s[DATA_W-1] != x[DATA_W-1]);
  endfunction

  function automatic logic sub_ovf(input logic [DATA_W-1:0] x, y, s);
    return (x[DATA_W-1] != y[DATA_W-1]) && (s[DATA_W-1] != x[DATA_W-1]);
  endfunction

  always_comb begin
    res     = a;
    res_ovf = 1'b0;
    acc_we  = 1'b0;
    flag_we = 1'b0;
    case (op)
      OP_LDA: begin
        res    = b;
        acc_we = 1'b1;
      end
      OP_ADD: begin
        res     = a + b;
        res_ovf = add_ovf(a, b, a + b);
        acc_we  = 1'b1;
        flag_we = 1'b1;
      end
      OP_SUB: begin
        res     = a - b;
        res_ovf = sub_ovf(a, b, a - b);
        acc_we  = 1'b1;
        flag_we = 1'b1;
      end
      OP_INC: begin
        res     = a + ONE;
        res_ovf = add_ovf(a, ONE, a + ONE);
        acc_we  = 1'b1;
        flag_we = 1'b1;
      end
      OP_DEC: begin
        res     = a - ONE;
        res_ovf = sub_ovf(a, ONE, a - ONE);
        acc_we  = 1'b1;
        flag_we = 1'b1;
      end
      default: ;
    endcase
    res_zero = (res == '0);
    is_equal = (a == b);
  end

endmodule

// File: rtl/acc_cpu_agu.sv
module acc_cpu_agu #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] opd,
  input  logic [ADDR_W-1:0] ix,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] idx_addr,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [DATA_W-1:0] imm_val
);

  function automatic logic [ADDR_W-1:0] offset_by(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] off);
    logic signed [ADDR_W:0] soff;
    logic [ADDR_W:0] sum;
    soff = {off[ADDR_W-1], off};
    sum  = {1'b0, base} + soff;
    return sum[ADDR_W-1:0];
  endfunction

  assign idx_addr = opd + ix;
  assign rel_addr = offset_by(pc, opd);
  assign imm_val  = {{(DATA_W-ADDR_W){1'b0}}, opd};

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] op,
  input  amode_e           mode,
  output state_e           state
);

  state_e nxt;

  always_comb begin
    nxt = ST_FADDR;
    case (state)
      ST_FADDR: nxt = ST_FREAD;
      ST_FREAD: nxt = ST_FCAP;
      ST_FCAP:  nxt = ST_CIR;
      ST_CIR:   nxt = ST_DECODE;
      ST_DECODE: begin
        if (op == OP_STA) begin
          if (mode == AM_IMM)      nxt = ST_FADDR;
          else if (mode == AM_IND) nxt = ST_PREAD;
          else                     nxt = ST_STORE;
        end else if (op_is_jump(op)) begin
          nxt = (mode == AM_IND) ? ST_OREAD : ST_EXEC;
        end else if (op_uses_data(op)) begin
          if (mode == AM_IMM)      nxt = ST_EXEC;
          else if (mode == AM_IND) nxt = ST_PREAD;
          else                     nxt = ST_OREAD;
        end else begin
          nxt = ST_EXEC;
        end
      end
      ST_PREAD: nxt = ST_PCAP;
      ST_PCAP:  nxt = ST_PMAR;
      ST_PMAR:  nxt = (op == OP_STA) ? ST_STORE : ST_OREAD;
      ST_OREAD: nxt = ST_OCAP;
      ST_OCAP:  nxt = ST_EXEC;
      default:  nxt = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FADDR;
    else     state <= nxt;
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W - MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [2:0]        status
);

  state_e            state;
  logic [ADDR_W-1:0] pc, mar, ix;
  logic [DATA_W-1:0] mdr, cir, acc;
  logic              flag_z, flag_v, flag_e;

  // instruction fields
  logic [OPC_W-1:0]  op;
  amode_e            mode;
  logic [ADDR_W-1:0] opd;
  assign op   = cir[DATA_W-1 -: OPC_W];
  assign mode = amode_e'(cir[ADDR_W +: MODE_W]);
  assign opd  = cir[ADDR_W-1:0];

  // named events for the checker
  logic ev_fetch_rd, ev_exec, ev_take_jump;
  logic take_jump;
  assign ev_fetch_rd  = (state == ST_FREAD);
  assign ev_exec      = (state == ST_EXEC);
  assign take_jump    = (op == OP_JMP) || ((op == OP_JPE) && flag_e) ||
                        ((op == OP_JPN) && !flag_e);
  assign ev_take_jump = ev_exec && take_jump;

  acc_cpu_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .mode  (mode),
    .state (state)
  );

  logic [ADDR_W-1:0] idx_addr, rel_addr;
  logic [DATA_W-1:0] imm_val;

  acc_cpu_agu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agu (
    .opd      (opd),
    .ix       (ix),
    .pc       (pc),
    .idx_addr (idx_addr),
    .rel_addr (rel_addr),
    .imm_val  (imm_val)
  );

  logic [DATA_W-1:0] alu_res;
  logic alu_z, alu_v, alu_acc_we, alu_flag_we, alu_eq;

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op),
    .a        (acc),
    .b        (mdr),
    .res      (alu_res),
    .res_zero (alu_z),
    .res_ovf  (alu_v),
    .acc_we   (alu_acc_we),
    .flag_we  (alu_flag_we),
    .is_equal (alu_eq)
  );

  logic [ADDR_W-1:0] jump_target;
  always_comb begin
    case (mode)
      AM_IMM:  jump_target = rel_addr;
      AM_DIR:  jump_target = opd;
      AM_IND:  jump_target = mdr[ADDR_W-1:0];
      default: jump_target = idx_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      mar    <= '0;
      mdr    <= '0;
      cir    <= '0;
      acc    <= '0;
      ix     <= '0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_e <= 1'b0;
    end else begin
      case (state)
        ST_FADDR: mar <= pc;
        ST_FREAD: pc  <= pc + 1'b1;
        ST_FCAP, ST_PCAP, ST_OCAP: mdr <= mem_rdata;
        ST_CIR:   cir <= mdr;
        ST_DECODE: begin
          mar <= (mode == AM_IDX) ? idx_addr : opd;
          if (mode == AM_IMM) mdr <= imm_val;
        end
        ST_PMAR:  mar <= mdr[ADDR_W-1:0];
        ST_EXEC: begin
          if (alu_acc_we) acc <= alu_res;
          if (alu_flag_we) begin
            flag_z <= alu_z;
            flag_v <= alu_v;
          end
          if (op == OP_CMP) flag_e <= alu_eq;
          if (op == OP_LIX) ix <= mdr[ADDR_W-1:0];
          if (take_jump) pc <= jump_target;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_rd    = (state == ST_FREAD) || (state == ST_PREAD) || (state == ST_OREAD);
  assign mem_wr    = (state == ST_STORE);
  assign mem_wdata = acc;
  assign status    = {flag_v, flag_z, flag_e};

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wr,
  input state_e            state,
  input logic [OPC_W-1:0]  op,
  input amode_e            mode,
  input logic [ADDR_W-1:0] pc,
  input logic [2:0]        status,
  input logic              ev_fetch_rd,
  input logic              ev_exec,
  input logic              ev_take_jump
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && status == 3'b000 && !mem_rd && !mem_wr));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    ev_fetch_rd |=> pc == ADDR_W'($past(pc) + 1'b1));

  assert_imm_no_read_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && mode == AM_IMM && op != OP_STA) |=> !mem_rd);

  assert_ptr_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PCAP) |-> $past(mem_rd));

  assert_imm_store_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && op == OP_STA && mode == AM_IMM) |=> !mem_wr);

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !ev_exec |=> $stable(status));

  assert_no_untaken_jump_R10: assert property (@(posedge clk) disable iff (rst)
    (ev_exec && !ev_take_jump) |=> $stable(pc));

  assert_rd_wr_excl_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}));

  assert_pc_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!ev_fetch_rd && !ev_exec) |=> $stable(pc));

endmodule

bind acc_cpu_core acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .state        (state),
  .op           (op),
  .mode         (mode),
  .pc           (pc),
  .status       (status),
  .ev_fetch_rd  (ev_fetch_rd),
  .ev_exec      (ev_exec),
  .ev_take_jump (ev_take_jump)
);

// File: tb/sim_acc_cpu_core.sv
`timescale 1ns/1ps
module sim_acc_cpu_core;

  localparam logic [3:0] C_LDA = 4'h0, C_STA = 4'h1, C_ADD = 4'h2, C_SUB = 4'h3,
                         C_INC = 4'h4, C_DEC = 4'h5, C_CMP = 4'h6, C_JMP = 4'h7,
                         C_JPE = 4'h8, C_JPN = 4'h9, C_LIX = 4'hA;
  localparam logic [1:0] M_IMM = 2'd0, M_DIR = 2'd1, M_IND = 2'd2, M_IDX = 2'd3;
  localparam logic [15:0] FILL = 16'hA5A5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [9:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [2:0]  status;

  acc_cpu_core u0 (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .status    (status)
  );

  // single-port memory, one cycle read latency, with a bench load path
  logic [15:0] mem [0:1023];
  logic        bk_clr = 1'b0, bk_we = 1'b0;
  logic [9:0]  bk_a = '0;
  logic [15:0] bk_d = '0;

  always @(posedge clk) begin
    if (bk_clr) begin
      for (int i = 0; i < 1024; i++) mem[i] <= FILL;
    end else if (bk_we) begin
      mem[bk_a] <= bk_d;
    end else if (mem_wr) begin
      mem[mem_addr] <= mem_wdata;
    end
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // port monitor, sampled mid-cycle
  int cyc, nwr, nboth, nrd;
  logic [9:0] rd_a [4];
  int rd_c [4];
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; nwr = 0; nboth = 0; nrd = 0;
    end else begin
      if (mem_rd && nrd < 4) begin
        rd_a[nrd] = mem_addr;
        rd_c[nrd] = cyc;
        nrd++;
      end
      if (mem_wr) nwr++;
      if (mem_rd && mem_wr) nboth++;
      cyc++;
    end
  end

  int n_cmp = 0, n_bad = 0;
  logic [2:0] st_cap;
  logic done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [1:0] md,
                                      input logic [9:0] o);
    return {op, md, o};
  endfunction

  // reference: {overflow, zero, result} from signed integer arithmetic
  function automatic logic [17:0] ref_arith(input logic [3:0] op, input logic [15:0] a,
                                            input logic [15:0] b);
    int sa, sb, r;
    logic [15:0] q;
    logic v;
    sa = int'($signed(a));
    sb = int'($signed(b));
    case (op)
      C_ADD:   r = sa + sb;
      C_SUB:   r = sa - sb;
      C_INC:   r = sa + 1;
      default: r = sa - 1;
    endcase
    v = (r > 32767) || (r < -32768);
    q = r[15:0];
    return {v, (q == 16'h0000), q};
  endfunction

  task automatic load_begin();
    @(posedge clk); #1 rst = 1'b1; bk_clr = 1'b1;
    @(posedge clk); #1 bk_clr = 1'b0;
  endtask

  task automatic poke(input logic [9:0] a, input logic [15:0] d);
    bk_a = a; bk_d = d; bk_we = 1'b1;
    @(posedge clk); #1 bk_we = 1'b0;
  endtask

  task automatic go(input int n);
    @(posedge clk); #1 rst = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk); st_cap = status;
    @(posedge clk); #1 rst = 1'b1;
  endtask

  task automatic run_arith(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [17:0] e;
    load_begin();
    poke(10'h000, ins(C_LDA, M_DIR, 10'h100));
    poke(10'h001, (op == C_INC || op == C_DEC) ? ins(op, M_IMM, 10'h000)
                                               : ins(op, M_DIR, 10'h101));
    poke(10'h002, ins(C_STA, M_DIR, 10'h200));
    poke(10'h003, ins(C_JMP, M_IMM, 10'h3FF));
    poke(10'h100, a);
    poke(10'h101, b);
    go(45);
    e = ref_arith(op, a, b);
    chk("R8 arithmetic result", 32'(mem[10'h200]), 32'(e[15:0]));
    chk("R8 R11 overflow/zero flags", 32'(st_cap[2:1]), 32'(e[17:16]));
    chk("R9 equality flag untouched by arithmetic", 32'(st_cap[0]), 32'(1'b0));
  endtask

  task automatic run_cmp(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    load_begin();
    poke(10'h000, ins(C_LDA, M_DIR, 10'h100));
    poke(10'h001, ins(C_SUB, M_DIR, 10'h100));
    poke(10'h002, ins(C_LDA, M_DIR, 10'h101));
    poke(10'h003, ins(C_CMP, M_DIR, 10'h102));
    poke(10'h004, ins(C_STA, M_DIR, 10'h200));
    poke(10'h005, ins(C_JMP, M_IMM, 10'h3FF));
    poke(10'h100, a);
    poke(10'h101, b);
    poke(10'h102, c);
    go(70);
    chk("R9 compare leaves ACC", 32'(mem[10'h200]), 32'(b));
    chk("R9 compare sets equality, keeps Z=1 V=0", 32'(st_cap), 32'({1'b0, 1'b1, (b == c)}));
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 mem_rd low in reset", 32'(mem_rd), 32'd0);
    chk("R1 mem_wr low in reset", 32'(mem_wr), 32'd0);
    chk("R1 status clear in reset", 32'(status), 32'd0);

    // directed program: all addressing modes and jump variants
    load_begin();
    poke(10'd0,  ins(C_LDA, M_IMM, 10'h155));
    poke(10'd1,  ins(C_STA, M_DIR, 10'h200));
    poke(10'd2,  ins(C_LDA, M_DIR, 10'h101));
    poke(10'd3,  ins(C_STA, M_DIR, 10'h201));
    poke(10'd4,  ins(C_LDA, M_IND, 10'h102));
    poke(10'd5,  ins(C_STA, M_IND, 10'h104));
    poke(10'd6,  ins(C_LIX, M_IMM, 10'd5));
    poke(10'd7,  ins(C_LDA, M_IDX, 10'h110));
    poke(10'd8,  ins(C_STA, M_IDX, 10'h1FE));
    poke(10'd9,  ins(C_STA, M_IMM, 10'h205));
    poke(10'd10, ins(C_JMP, M_IMM, 10'd1));
    poke(10'd11, ins(C_STA, M_DIR, 10'h206));
    poke(10'd12, ins(C_JMP, M_DIR, 10'd14));
    poke(10'd13, ins(C_STA, M_DIR, 10'h207));
    poke(10'd14, ins(C_LDA, M_IMM, 10'd7));
    poke(10'd15, ins(C_CMP, M_IMM, 10'd7));
    poke(10'd16, ins(C_JPE, M_DIR, 10'd18));
    poke(10'd17, ins(C_STA, M_DIR, 10'h208));
    poke(10'd18, ins(C_CMP, M_IMM, 10'd8));
    poke(10'd19, ins(C_JPN, M_IDX, 10'd16));
    poke(10'd20, ins(C_STA, M_DIR, 10'h209));
    poke(10'd21, ins(C_JPE, M_DIR, 10'd23));
    poke(10'd22, ins(C_STA, M_DIR, 10'h20A));
    poke(10'd23, ins(C_JMP, M_IND, 10'h105));
    poke(10'd24, ins(C_STA, M_DIR, 10'h20B));
    poke(10'd25, ins(C_JMP, M_IMM, 10'h3FF));
    poke(10'h101, 16'hBEEF);
    poke(10'h102, 16'h0103);
    poke(10'h103, 16'h1234);
    poke(10'h104, 16'h0202);
    poke(10'h105, 16'd25);
    poke(10'h115, 16'h8001);
    go(500);
    chk("R1 first fetch read address", 32'(rd_a[0]), 32'd0);
    chk("R2 first fetch read cycle", 32'(rd_c[0]), 32'd1);
    chk("R2 second fetch address after PC increment", 32'(rd_a[1]), 32'd1);
    chk("R2 second fetch read cycle", 32'(rd_c[1]), 32'd7);
    chk("R3 R4 immediate load stored", 32'(mem[10'h200]), 32'h0155);
    chk("R5 direct load", 32'(mem[10'h201]), 32'hBEEF);
    chk("R5 indirect load and indirect store", 32'(mem[10'h202]), 32'h1234);
    chk("R6 indexed load and indexed store", 32'(mem[10'h203]), 32'h8001);
    chk("R7 immediate-mode store writes nothing", 32'(mem[10'h205]), 32'(FILL));
    chk("R10 relative jump skips", 32'(mem[10'h206]), 32'(FILL));
    chk("R10 direct jump skips", 32'(mem[10'h207]), 32'(FILL));
    chk("R10 JPE taken when equal", 32'(mem[10'h208]), 32'(FILL));
    chk("R10 JPN indexed taken when not equal", 32'(mem[10'h209]), 32'(FILL));
    chk("R10 JPE not taken when not equal", 32'(mem[10'h20A]), 32'h0007);
    chk("R10 indirect jump skips", 32'(mem[10'h20B]), 32'(FILL));
    chk("R7 total store strobes", 32'(nwr), 32'd5);
    chk("R12 read and write never together", 32'(nboth), 32'd0);
    chk("R8 R11 loads leave Z and V clear", 32'(st_cap), 32'd0);

    // R6: index wrap modulo 1024
    load_begin();
    poke(10'd0, ins(C_LIX, M_IMM, 10'h3FF));
    poke(10'd1, ins(C_LDA, M_IDX, 10'h101));
    poke(10'd2, ins(C_STA, M_DIR, 10'h200));
    poke(10'd3, ins(C_JMP, M_IMM, 10'h3FF));
    poke(10'h100, 16'h4321);
    go(45);
    chk("R6 indexed address wraps", 32'(mem[10'h200]), 32'h4321);

    // directed arithmetic corners
    run_arith(C_INC, 16'h7FFF, 16'h0000);
    run_arith(C_DEC, 16'h8000, 16'h0000);
    run_arith(C_ADD, 16'h7FFF, 16'h0001);
    run_arith(C_SUB, 16'h8000, 16'h0001);
    run_arith(C_SUB, 16'h1234, 16'h1234);
    run_arith(C_ADD, 16'hFFFF, 16'h0001);
    run_arith(C_DEC, 16'h0001, 16'h0000);

    // random arithmetic
    for (int k = 0; k < 30; k++) begin
      logic [3:0] op;
      logic [15:0] a, b;
      op = 4'(C_ADD + ($urandom % 4));
      a = 16'($urandom);
      b = ((k % 5) == 0) ? a : 16'($urandom);
      run_arith(op, a, b);
    end

    // compare: equal and unequal
    for (int k = 0; k < 8; k++) begin
      logic [15:0] b, c;
      b = 16'($urandom);
      c = (k[0]) ? b : 16'(b ^ (16'd1 << ($urandom % 16)));
      run_cmp(16'($urandom), b, c);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule